// File: doc/BRIEF.md
# Open-Drain Capable Serial Byte Master

This block is an 8-bit full-duplex serial master. A bus write hands it a byte and starts a transfer. The block generates the serial clock from the system clock, moves the byte out on the data-out line with the most significant bit first, and captures one bit from the data-in line for every bit it sends. When the last clock edge of the byte has passed, the captured byte goes into a read buffer, and a one-cycle done pulse marks the update. No separate transmit-empty or receive-full flags exist, because every byte sent is exchanged for a byte received.

Clock polarity and phase inputs set the idle level of the serial clock and choose which edges sample and which edges shift. A two-bit rate code divides the system clock by one of four fixed ratios. When the block is disabled, both serial outputs are released to high impedance, shown here as low output-enables. The data-in line passes through a digital filter that discards single-cycle spikes. In open-drain mode the data output only pulls the line low. If the block releases the line but reads a low level back at a sampling edge, it has lost arbitration. It then keeps the line released for the rest of the byte and raises a lost flag.

Top module: `spi_od_master`

## Requirements
- R1: With `enable` high and no transfer active, `wr_en` loads `wr_data` and starts a transfer. `busy` is high from the next cycle for exactly 16 half periods of the serial clock.
- R2: Data leaves on `sdo_o` with the most significant bit first. Each bit is stable for at least one half period of the serial clock before the edge that samples it.
- R3: While idle, `sck_o` follows `cpol` one cycle later. A byte takes 16 toggles of `sck_o`. With `cpha`=0, edges 1,3,..,15 sample and edges 2,4,..,16 shift. With `cpha`=1, edges 2,4,..,16 sample, edges 3,5,..,15 shift, and the first bit is already on the line at load.
- R4: One cycle after `enable` goes low, `sck_oe`, `sdo_oe` and `busy` are low. A transfer in progress is abandoned with no `done` pulse, and the read buffer keeps its value.
- R5: `rate` 0, 1, 2 and 3 divide the system clock by 2, 4, 16 and 32. A byte then keeps `busy` high for 16, 32, 128 or 256 cycles.
- R6: At the 16th edge, `rd_data` takes the eight sampled bits, first sample in bit 7. `done` is high for that one cycle, and `busy` falls in the same cycle.
- R7: `wr_en` during a transfer is ignored. It neither restarts the transfer nor changes the byte being sent.
- R8: The data-in line is filtered. A new level counts only after it is seen on two successive clocks, and the filtered level trails the pin by three clocks. A one-cycle pulse never reaches the sampler.
- R9: With `open_drain` high, `sdo_oe` is high only while `sdo_o` is 0. With it low, `sdo_oe` follows `enable`.
- R10: In open-drain mode, a sampling edge that finds the filtered input at 0 while `sdo_o` is 1 sets `arb_lost`. After that, `sdo_o` stays 1 until the byte ends. `arb_lost` holds until the next load, which clears it. Push-pull mode never sets it.
- R11: Outside a transfer `sdo_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low releases both outputs |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Sampling phase select |
| rate | input | 2 | Clock divider code |
| open_drain | input | 1 | Shared-bus open-drain mode |
| wr_en | input | 1 | Write strobe that starts a transfer |
| wr_data | input | 8 | Byte to send |
| sdi | input | 1 | Serial data in |
| sck_o | output | 1 | Serial clock level |
| sck_oe | output | 1 | Serial clock output enable |
| sdo_o | output | 1 | Serial data out level |
| sdo_oe | output | 1 | Serial data output enable |
| rd_data | output | 8 | Read buffer, last received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on read buffer update |
| arb_lost | output | 1 | Arbitration lost during this byte |

## Verification
Bytes looped back from `sdo_o` to `sdi` under all four clock modes expose any mistake in bit order or in the choice of sampling edge. A constant data-in level at each rate code separates the four divide ratios by transfer length. Trains of one-cycle spikes on an otherwise high input separate a working filter from a plain synchronizer. A wired-AND line that a far end pulls low, used in both output modes, separates arbitration loss from ordinary reception. Finally, random per-cycle input at every rate, compared with a reference model on every clock, pins down the filter lag and the exact sampling cycle.

// File: rtl/spi_od_pkg.sv
package spi_od_pkg;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned HALF_W = 5;

  localparam int unsigned DIV_R0 = 2;
  localparam int unsigned DIV_R1 = 4;
  localparam int unsigned DIV_R2 = 16;
  localparam int unsigned DIV_R3 = 32;

  typedef enum logic [1:0] {
    RATE_FAST_A = 2'd0,
    RATE_FAST_B = 2'd1,
    RATE_MED_A  = 2'd2,
    RATE_MED_B  = 2'd3
  } rate_sel_e;

  // system clocks per half period of the serial clock
  function automatic logic [HALF_W-1:0] half_of(input rate_sel_e r);
    case (r)
      RATE_FAST_A: half_of = HALF_W'(DIV_R0 / 2);
      RATE_FAST_B: half_of = HALF_W'(DIV_R1 / 2);
      RATE_MED_A:  half_of = HALF_W'(DIV_R2 / 2);
      default:     half_of = HALF_W'(DIV_R3 / 2);
    endcase
  endfunction

endpackage

// File: rtl/spi_od_edge_timer.sv
module spi_od_edge_timer #(
  parameter int unsigned HW = 5,
  parameter int unsigned EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          run,
  input  logic [HW-1:0] half_len,
  output logic          tick,
  output logic [EW-1:0] edge_idx
);

  logic [HW-1:0] len_q;
  logic [HW-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q    <= '0;
      cnt_q    <= '0;
      edge_idx <= '0;
    end else if (start) begin
      len_q    <= half_len;
      cnt_q    <= half_len - 1'b1;
      edge_idx <= '0;
    end else if (run) begin
      if (cnt_q == '0) begin
        cnt_q    <= len_q - 1'b1;
        edge_idx <= edge_idx + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R5: the half-period counter never leaves the range set at start
  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < len_q));

endmodule

// File: rtl/spi_od_in_filter.sv
module spi_od_in_filter #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= IDLE_LVL;
      s2_q <= IDLE_LVL;
      filt <= IDLE_LVL;
    end else begin
      s1_q <= raw;
      s2_q <= s1_q;
      if (s1_q == s2_q) filt <= s1_q;
    end
  end

  // R8: a new filtered level was present on the pin for two clocks in a row
  a_r8_settled_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> (filt == $past(raw, 2)) && (filt == $past(raw, 3)));

endmodule

// File: rtl/spi_od_shifter.sv
module spi_od_shifter #(
  parameter int unsigned W  = 8,
  parameter int unsigned EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [W-1:0]  load_data,
  input  logic          abort,
  input  logic          tick,
  input  logic [EW-1:0] edge_idx,
  input  logic          cpha,
  input  logic          od,
  input  logic          din,
  output logic          sdo_lvl,
  output logic [W-1:0]  rd_data,
  output logic          lost
);

  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * W - 1);

  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;
  logic [W-1:0] rx_next;
  logic         sample_edge;
  logic         shift_edge;
  logic         last_edge;

  always_comb begin
    sample_edge = tick && (edge_idx[0] == cpha);
    shift_edge  = tick && (edge_idx[0] != cpha) && (edge_idx != '0);
    last_edge   = tick && (edge_idx == LAST_EDGE);
    rx_next     = {rx_q[W-2:0], din};
  end

  assign sdo_lvl = tx_q[W-1] | lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q    <= '1;
      rx_q    <= '0;
      rd_data <= '0;
      lost    <= 1'b0;
    end else if (load) begin
      tx_q <= load_data;
      rx_q <= '0;
      lost <= 1'b0;
    end else if (abort) begin
      tx_q <= '1;
    end else begin
      if (sample_edge) begin
        rx_q <= rx_next;
        if (od && sdo_lvl && !din) lost <= 1'b1;
      end
      if (last_edge) begin
        tx_q    <= '1;
        rd_data <= sample_edge ? rx_next : rx_q;
      end else if (shift_edge) begin
        tx_q <= {tx_q[W-2:0], 1'b1};
      end
    end
  end

  // R2: the top bit of a freshly loaded byte is on the line one cycle later
  a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (sdo_lvl == $past(load_data[W-1])));

endmodule

// File: rtl/spi_od_master.sv
module spi_od_master
  import spi_od_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned HW = HALF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         cpol,
  input  logic         cpha,
  input  logic [1:0]   rate,
  input  logic         open_drain,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         sdi,
  output logic         sck_o,
  output logic         sck_oe,
  output logic         sdo_o,
  output logic         sdo_oe,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         done,
  output logic         arb_lost
);

  localparam int unsigned     EW        = $clog2(2 * W);
  localparam logic [EW-1:0]   LAST_EDGE = EW'(2 * W - 1);

  logic          busy_q;
  logic          done_q;
  logic          sck_q;
  logic          en_q;
  logic          od_q;
  logic          cpha_q;
  logic          start;
  logic          abort;
  logic          last;
  logic          tick;
  logic [EW-1:0] edge_idx;
  logic          din_f;
  logic          sdo_lvl;
  logic [HW-1:0] half_len;

  assign half_len = HW'(half_of(rate_sel_e'(rate)));
  assign start    = enable && wr_en && !busy_q;
  assign abort    = busy_q && !enable;
  assign last     = tick && enable && (edge_idx == LAST_EDGE);

  spi_od_edge_timer #(.HW(HW), .EW(EW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .run      (busy_q),
    .half_len (half_len),
    .tick     (tick),
    .edge_idx (edge_idx)
  );

  spi_od_in_filter #(.IDLE_LVL(1'b1)) u_filter (
    .clk  (clk),
    .rst  (rst),
    .raw  (sdi),
    .filt (din_f)
  );

  spi_od_shifter #(.W(W), .EW(EW)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .load      (start),
    .load_data (wr_data),
    .abort     (abort),
    .tick      (tick),
    .edge_idx  (edge_idx),
    .cpha      (cpha_q),
    .od        (od_q),
    .din       (din_f),
    .sdo_lvl   (sdo_lvl),
    .rd_data   (rd_data),
    .lost      (arb_lost)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      en_q   <= 1'b0;
      od_q   <= 1'b0;
      cpha_q <= 1'b0;
    end else begin
      en_q   <= enable;
      od_q   <= open_drain;
      done_q <= last;
      if (start) cpha_q <= cpha;
      if (!enable)    busy_q <= 1'b0;
      else if (start) busy_q <= 1'b1;
      else if (last)  busy_q <= 1'b0;
      if (!enable || !busy_q) sck_q <= cpol;
      else if (tick)          sck_q <= ~sck_q;
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = en_q;
  assign sdo_o  = sdo_lvl;
  assign sdo_oe = en_q && (!od_q || !sdo_lvl);
  assign busy   = busy_q;
  assign done   = done_q;

  // R4: disabling releases the pins and stops any transfer
  a_r4_disable_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sck_oe && !sdo_oe && !busy_q && !done_q));

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6: done marks the end of a busy period
  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (!busy_q && $past(busy_q)));

  // R3: the idle clock level tracks the polarity input
  a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && $past(!busy_q) && !$past(rst)) |-> (sck_q == $past(cpol)));

  // R11: the data line rests high between transfers
  a_r11_idle_release: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> sdo_lvl);

  // R10: the lost flag holds until a new byte is loaded
  a_r10_lost_sticky: assert property (@(posedge clk) disable iff (rst)
    (arb_lost && !start) |=> arb_lost);

endmodule

// File: tb/spi_od_master_bench.sv
module spi_od_master_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [1:0] rate = 2'd0;
  logic       open_drain = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sdi_drv = 1'b1;
  logic       lb = 1'b0;
  logic       rnd_sdi = 1'b0;
  logic       sdi;
  logic       sck_o, sck_oe, sdo_o, sdo_oe, busy, done, arb_lost;
  logic [7:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  int wd = 0;

  always #2.5ns clk = ~clk;

  // wired-AND line when looped back, plain drive otherwise
  assign sdi = lb ? ((sdo_oe ? sdo_o : 1'b1) & sdi_drv) : sdi_drv;

  spi_od_master u_spi_od_master (
    .clk(clk), .rst(rst), .enable(enable), .cpol(cpol), .cpha(cpha),
    .rate(rate), .open_drain(open_drain), .wr_en(wr_en), .wr_data(wr_data),
    .sdi(sdi), .sck_o(sck_o), .sck_oe(sck_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .rd_data(rd_data), .busy(busy), .done(done), .arb_lost(arb_lost)
  );

  // ---------------- reference model ----------------
  logic       m_busy = 0, m_done = 0, m_sck = 0, m_en = 0, m_od = 0, m_pha = 0;
  logic       m_lost = 0, f1 = 1, f2 = 1, ff = 1, smp;
  logic [7:0] m_tx = 8'hFF, m_rx = 0, m_rd = 0;
  int         m_left = 0, m_half = 1, m_edge = 0;

  // R5: divide ratios 2,4,16,32 give half periods of 1,2,8,16 clocks
  function automatic int half_cycles(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_sck = 0; m_en = 0; m_od = 0; m_pha = 0;
      m_tx = 8'hFF; m_rx = 0; m_rd = 0; m_lost = 0;
      f1 = 1; f2 = 1; ff = 1;
    end else begin
      m_done = 0;
      if (!enable) begin
        if (m_busy) m_tx = 8'hFF;
        m_busy = 0;
        m_sck = cpol;
      end else if (!m_busy) begin
        m_sck = cpol;
        if (wr_en) begin
          m_busy = 1; m_tx = wr_data; m_rx = 0; m_lost = 0;
          m_half = half_cycles(rate); m_left = m_half; m_edge = 0; m_pha = cpha;
        end
      end else begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_left = m_half;
          m_sck = ~m_sck;
          smp = ((m_edge % 2) == int'(m_pha));
          if (smp) begin
            if (m_od && (m_tx[7] | m_lost) && !ff) m_lost = 1;
            m_rx = {m_rx[6:0], ff};
          end else if (m_edge != 0) begin
            m_tx = {m_tx[6:0], 1'b1};
          end
          if (m_edge == 15) begin
            m_busy = 0; m_done = 1; m_rd = m_rx; m_tx = 8'hFF;
          end
          m_edge = m_edge + 1;
        end
      end
      ff = (f1 == f2) ? f1 : ff;
      f2 = f1;
      f1 = sdi;
      m_en = enable;
      m_od = open_drain;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  logic exp_sdo, exp_oe;
  always @(negedge clk) begin
    exp_sdo = m_tx[7] | m_lost;
    exp_oe  = m_en && (!m_od || !exp_sdo);
    chk(sck_o === m_sck, "R3 clock level", 32'(sck_o), 32'(m_sck));
    chk(sck_oe === m_en, "R4 clock enable", 32'(sck_oe), 32'(m_en));
    chk(sdo_o === exp_sdo, "R2 data out", 32'(sdo_o), 32'(exp_sdo));
    chk(sdo_oe === exp_oe, "R9 data drive", 32'(sdo_oe), 32'(exp_oe));
    chk(busy === m_busy, "R1 busy", 32'(busy), 32'(m_busy));
    chk(done === m_done, "R6 done", 32'(done), 32'(m_done));
    chk(rd_data === m_rd, "R6 read buffer", 32'(rd_data), 32'(m_rd));
    chk(arb_lost === m_lost, "R10 lost flag", 32'(arb_lost), 32'(m_lost));
    if (rnd_sdi) sdi_drv = 1'($urandom);
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected below 150000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_idle(input bit glitch, output int cyc, output int tog,
                          output int oe_bad, output int hi_cnt, output int dn);
    logic prev;
    cyc = 0; tog = 0; oe_bad = 0; hi_cnt = 0; dn = 0;
    prev = sck_o;
    while (busy) begin
      if (glitch) sdi_drv = (cyc % 4 == 1) ? 1'b0 : 1'b1;
      @(negedge clk);
      cyc++;
      if (sck_o !== prev) tog++;
      prev = sck_o;
      if (sdo_oe && sdo_o) oe_bad++;
      if (sdo_o) hi_cnt++;
      if (done) dn++;
    end
    if (glitch) sdi_drv = 1'b1;
  endtask

  int cyc, tog, oe_bad, hi_cnt, dn;

  initial begin
    repeat (4) @(negedge clk);
    // R4: reset state with the block disabled
    chk(!sck_oe && !sdo_oe, "R4 reset outputs released", {30'd0, sck_oe, sdo_oe}, 0);
    chk(!busy && !done && rd_data == 8'h00, "R6 reset idle", {23'd0, busy, done, rd_data}, 0);
    @(negedge clk); rst = 1'b0; enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(sdo_o === 1'b1, "R11 idle data high", 32'(sdo_o), 1);

    // R1 R5 R6: loopback at rate 2
    lb = 1; rate = 2'd2;
    send(8'hA5);
    chk(busy === 1'b1, "R1 busy after write", 32'(busy), 1);
    run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    chk(rd_data == 8'hA5, "R6 loopback byte", rd_data, 8'hA5);
    chk(cyc == 128, "R5 divide 16 length", cyc, 128);
    chk(dn == 1, "R6 one done pulse", dn, 1);
    chk(sdo_o === 1'b1, "R11 data high after byte", 32'(sdo_o), 1);

    // R5: each rate with constant low input
    lb = 0; sdi_drv = 0;
    for (int r = 0; r < 4; r++) begin
      rate = 2'(r);
      repeat (4) @(negedge clk);
      send(8'h69);
      run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
      chk(cyc == 8 * 2 * half_cycles(2'(r)), "R5 transfer length", cyc, 16 * half_cycles(2'(r)));
    end
    chk(rd_data == 8'h00, "R6 constant low byte", rd_data, 0);

    // R3: all clock modes, loopback at slowest rate
    lb = 1; sdi_drv = 1; rate = 2'd3;
    for (int m = 0; m < 4; m++) begin
      cpol = m[1]; cpha = m[0];
      repeat (3) @(negedge clk);
      chk(sck_o === cpol, "R3 idle clock level", 32'(sck_o), 32'(cpol));
      send(8'h3C ^ 8'(m * 17));
      run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
      chk(tog == 16, "R3 clock toggles per byte", tog, 16);
      chk(rd_data == (8'h3C ^ 8'(m * 17)), "R3 mode loopback byte", rd_data, 8'h3C ^ 8'(m * 17));
    end
    cpol = 0; cpha = 0;

    // R7: write during transfer is ignored
    rate = 2'd2;
    send(8'h81);
    repeat (10) @(negedge clk);
    send(8'h7E);
    run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    chk(rd_data == 8'h81, "R7 busy write ignored", rd_data, 8'h81);
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R7 no second transfer", 32'(busy), 0);

    // R8: single-cycle spikes on a high input
    lb = 0; sdi_drv = 1; rate = 2'd3;
    repeat (4) @(negedge clk);
    send(8'h00);
    run_idle(1, cyc, tog, oe_bad, hi_cnt, dn);
    chk(rd_data == 8'hFF, "R8 spikes filtered", rd_data, 8'hFF);

    // R9 R10: open-drain, no contention
    open_drain = 1; lb = 1; sdi_drv = 1;
    repeat (3) @(negedge clk);
    send(8'h0F);
    run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    chk(oe_bad == 0, "R9 drive only low", oe_bad, 0);
    chk(rd_data == 8'h0F && !arb_lost, "R10 clean shared byte", {arb_lost, rd_data}, 8'h0F);

    // R10: far end holds the line low
    sdi_drv = 0;
    send(8'hFF);
    run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    chk(arb_lost === 1'b1, "R10 loss detected", 32'(arb_lost), 1);
    chk(hi_cnt == cyc, "R10 line stays released", hi_cnt, cyc);
    sdi_drv = 1;
    repeat (4) @(negedge clk);
    send(8'h55);
    chk(arb_lost === 1'b0, "R10 cleared on load", 32'(arb_lost), 0);
    run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    chk(rd_data == 8'h55, "R10 byte after loss", rd_data, 8'h55);

    // R10: push-pull never flags loss
    open_drain = 0; lb = 0; sdi_drv = 0;
    repeat (4) @(negedge clk);
    send(8'hFF);
    run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    chk(arb_lost === 1'b0, "R10 push-pull no loss", 32'(arb_lost), 0);

    // R4: abort mid-transfer
    rate = 2'd3; sdi_drv = 1;
    send(8'h12);
    repeat (40) @(negedge clk);
    enable = 0;
    @(negedge clk);
    chk(!sck_oe && !sdo_oe && !busy, "R4 disable releases", {29'd0, sck_oe, sdo_oe, busy}, 0);
    chk(rd_data == 8'h00, "R4 buffer kept", rd_data, 8'h00);
    enable = 1;
    repeat (3) @(negedge clk);
    chk(!done && !busy && rd_data == 8'h00, "R4 no completion", {22'd0, done, busy, rd_data}, 0);

    // random configurations and per-cycle random input
    rnd_sdi = 1;
    for (int i = 0; i < 30; i++) begin
      cpol = 1'($urandom); cpha = 1'($urandom); rate = 2'($urandom);
      open_drain = 1'($urandom);
      repeat (2) @(negedge clk);
      send(8'($urandom));
      run_idle(0, cyc, tog, oe_bad, hi_cnt, dn);
    end
    rnd_sdi = 0;
    repeat (5) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule